// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block keeps the single output-compare state bit of one timer channel and decides what appears on the I/O pin that the channel shares with a general-purpose port. A two-bit action field chooses how the state bit reacts to a compare event. The choices are leave it alone, invert it, drive it low or drive it high. A compare event is either a real match strobe from the counter or a software force strobe. A direct preset path loads the state bit outright, so firmware can give it a known level before the pin is handed to the timer.

Pin ownership depends only on the action field. When the field is zero, the port data bit reaches the pin. When it is non-zero, the state bit reaches the pin instead. The output enable always follows the direction bit, so the compare level only becomes visible once the direction selects output. The state register drives the pin path directly, with no further register, so a change of the state bit shows on the pin in the cycle that follows the event.

Top module: `cmp_out_pin_unit`

## Requirements
- R1: While reset is asserted, and directly after it is released, the state output `oc_state_o` is 0.
- R2: With `mode_i` = 2'b01, a compare event (`match_i` or `force_i` high at a rising edge) inverts the state bit at that edge.
- R3: With `mode_i` = 2'b10, a compare event drives the state bit to 0.
- R4: With `mode_i` = 2'b11, a compare event drives the state bit to 1.
- R5: With `mode_i` = 2'b00, compare events leave the state bit unchanged. With no event and no preset, the state bit holds in every mode.
- R6: A `force_i` pulse applies the selected action exactly as a `match_i` pulse does.
- R7: When `match_i` and `force_i` are both high at the same edge, the action is applied once. In toggle mode the bit therefore inverts once and does not return to its old value.
- R8: When `mode_i` is non-zero, `pin_o` equals the state bit. When `mode_i` is 2'b00, `pin_o` equals `port_data_i`.
- R9: `pin_oe_o` equals `port_dir_i` (1 = output) in every mode.
- R10: `preset_we_i` loads `preset_val_i` into the state bit at the edge in any mode, and it takes priority over a compare event at that same edge. With `mode_i` = 2'b00 the preset does not change `pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| match_i | input | 1 | Single-cycle compare-match strobe |
| force_i | input | 1 | Single-cycle software force strobe |
| mode_i | input | 2 | Action field: 00 off, 01 toggle, 10 clear, 11 set |
| preset_we_i | input | 1 | Direct load strobe for the state bit |
| preset_val_i | input | 1 | Value loaded by the preset strobe |
| port_data_i | input | 1 | General-purpose port data bit |
| port_dir_i | input | 1 | Direction bit, 1 = output |
| pin_o | output | 1 | Value presented to the pin driver |
| pin_oe_o | output | 1 | Pin driver enable |
| oc_state_o | output | 1 | Internal output-compare state bit |

## Verification
A wrong state bit appears on `oc_state_o` one cycle after the event that caused it. When the action field is non-zero and the direction bit selects output, it also appears on `pin_o` in that same cycle, because no register sits between the state and the pin. A preset made while the port owns the pin, or a double action when both strobes arrive together, leaves no mark on the pin. It only shows later, when the state bit is read or the action field hands the pin to the timer. The bench therefore compares the state output after every edge as well as the pin.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

    typedef enum logic [1:0] {
        CMO_OFF    = 2'b00,
        CMO_TOGGLE = 2'b01,
        CMO_CLEAR  = 2'b10,
        CMO_SET    = 2'b11
    } cmo_mode_e;

    typedef struct packed {
        logic oc_bit;
    } cmo_state_t;

    localparam cmo_state_t CMO_RESET_STATE = '{oc_bit: 1'b0};

endpackage

// File: rtl/cmo_action.sv
module cmo_action
    import cmp_out_pkg::*;
(
    input  logic      cur_i,
    input  cmo_mode_e mode_i,
    output logic      next_o
);
    always_comb begin
        unique case (mode_i)
            CMO_TOGGLE: next_o = ~cur_i;
            CMO_CLEAR:  next_o = 1'b0;
            CMO_SET:    next_o = 1'b1;
            default:    next_o = cur_i;
        endcase
    end
endmodule

// File: rtl/cmo_pin_mux.sv
module cmo_pin_mux
    import cmp_out_pkg::*;
(
    input  cmo_mode_e mode_i,
    input  logic      oc_bit_i,
    input  logic      port_data_i,
    input  logic      port_dir_i,
    output logic      pin_o,
    output logic      pin_oe_o
);
    logic owned;

    always_comb begin
        owned    = (mode_i != CMO_OFF);
        pin_o    = owned ? oc_bit_i : port_data_i;
        pin_oe_o = port_dir_i;
    end
endmodule

// File: rtl/cmp_out_pin_unit.sv
module cmp_out_pin_unit
    import cmp_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match_i,
    input  logic       force_i,
    input  logic [1:0] mode_i,
    input  logic       preset_we_i,
    input  logic       preset_val_i,
    input  logic       port_data_i,
    input  logic       port_dir_i,
    output logic       pin_o,
    output logic       pin_oe_o,
    output logic       oc_state_o
);
    cmo_state_t st_d, st_q;
    cmo_mode_e  mode_e;
    logic       act_bit;
    logic       cmp_event;

    assign mode_e = cmo_mode_e'(mode_i);

    cmo_action u_action (
        .cur_i  (st_q.oc_bit),
        .mode_i (mode_e),
        .next_o (act_bit)
    );

    // next-state: preset first, otherwise one action per edge for any event
    always_comb begin
        st_d      = st_q;
        cmp_event = match_i | force_i;
        if (preset_we_i) begin
            st_d.oc_bit = preset_val_i;
        end else if (cmp_event) begin
            st_d.oc_bit = act_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CMO_RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    cmo_pin_mux u_mux (
        .mode_i      (mode_e),
        .oc_bit_i    (st_q.oc_bit),
        .port_data_i (port_data_i),
        .port_dir_i  (port_dir_i),
        .pin_o       (pin_o),
        .pin_oe_o    (pin_oe_o)
    );

    assign oc_state_o = st_q.oc_bit;
endmodule

// File: rtl/cmp_out_pin_unit_chk.sv
module cmp_out_pin_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       match_i,
    input logic       force_i,
    input logic [1:0] mode_i,
    input logic       preset_we_i,
    input logic       preset_val_i,
    input logic       port_data_i,
    input logic       port_dir_i,
    input logic       pin_o,
    input logic       pin_oe_o,
    input logic       oc_state_o
);
    logic evt;
    assign evt = match_i | force_i;

    assert_toggle_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !preset_we_i && mode_i == 2'b01) |=> (oc_state_o != $past(oc_state_o)));

    assert_clear_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !preset_we_i && mode_i == 2'b10) |=> !oc_state_o);

    assert_set_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !preset_we_i && mode_i == 2'b11) |=> oc_state_o);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_we_i && (!evt || mode_i == 2'b00)) |=> $stable(oc_state_o));

    assert_pin_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_o == ((mode_i != 2'b00) ? oc_state_o : port_data_i));

    assert_oe_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o == port_dir_i);

    assert_preset_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        preset_we_i |=> (oc_state_o == $past(preset_val_i)));
endmodule

bind cmp_out_pin_unit cmp_out_pin_unit_chk u_chk (.*);

// File: tb/cmp_out_pin_unit_test.sv
module cmp_out_pin_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       match_i = 1'b0, force_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       preset_we_i = 1'b0, preset_val_i = 1'b0;
    logic       port_data_i = 1'b0, port_dir_i = 1'b0;
    logic       pin_o, pin_oe_o, oc_state_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_out_pin_unit uut (.*);

    typedef struct packed {
        logic       we, val, mt, fc;
        logic [1:0] md;
        logic       pd, dr, es, ep, eo;
    } vec_t;

    // we val mt fc md pd dr | exp_state exp_pin exp_oe ; state starts at 0
    localparam vec_t VECS [14] = '{
        '{1'b0,1'b0,1'b1,1'b0,2'b11,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R4 set
        '{1'b0,1'b0,1'b1,1'b0,2'b01,1'b0,1'b1, 1'b0,1'b0,1'b1}, // R2 toggle
        '{1'b0,1'b0,1'b0,1'b1,2'b01,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R6 force toggle
        '{1'b0,1'b0,1'b1,1'b1,2'b01,1'b0,1'b1, 1'b0,1'b0,1'b1}, // R7 both once
        '{1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R6 force set
        '{1'b0,1'b0,1'b1,1'b0,2'b10,1'b1,1'b1, 1'b0,1'b0,1'b1}, // R3 clear
        '{1'b0,1'b0,1'b1,1'b0,2'b00,1'b1,1'b1, 1'b0,1'b1,1'b1}, // R5 R8 off
        '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b0,1'b1, 1'b1,1'b0,1'b1}, // R10 preset hidden
        '{1'b0,1'b0,1'b0,1'b1,2'b00,1'b1,1'b0, 1'b1,1'b0,1'b0}, // R5 R9 input dir
        '{1'b0,1'b0,1'b0,1'b0,2'b10,1'b0,1'b0, 1'b1,1'b0,1'b0}, // R9 owned but input
        '{1'b0,1'b0,1'b0,1'b0,2'b10,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R8 state on pin
        '{1'b1,1'b0,1'b1,1'b0,2'b11,1'b1,1'b1, 1'b0,1'b0,1'b1}, // R10 priority
        '{1'b0,1'b0,1'b0,1'b0,2'b01,1'b1,1'b1, 1'b0,1'b0,1'b1}, // R5 hold
        '{1'b0,1'b0,1'b1,1'b0,2'b01,1'b0,1'b1, 1'b1,1'b1,1'b1}  // R2 toggle up
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #4000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", oc_state_o, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1 after release", oc_state_o, 1'b0);

        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            preset_we_i  = VECS[i].we;
            preset_val_i = VECS[i].val;
            match_i      = VECS[i].mt;
            force_i      = VECS[i].fc;
            mode_i       = VECS[i].md;
            port_data_i  = VECS[i].pd;
            port_dir_i   = VECS[i].dr;
            @(posedge clk);
            #1;
            check($sformatf("R2-R10 vec%0d state", i), oc_state_o, VECS[i].es);
            check($sformatf("R9 vec%0d oe", i), pin_oe_o, VECS[i].eo);
            if (VECS[i].dr) check($sformatf("R8 vec%0d pin", i), pin_o, VECS[i].ep);
            @(negedge clk);
            preset_we_i = 1'b0; match_i = 1'b0; force_i = 1'b0;
        end

        // R1: reset in mid-run clears a state bit of 1
        @(negedge clk); mode_i = 2'b11; match_i = 1'b1;
        @(negedge clk); match_i = 1'b0;
        check("R4 before reset", oc_state_o, 1'b1);
        rst_n = 1'b0;
        #1 check("R1 mid-run reset", oc_state_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 held after reset", oc_state_o, 1'b0);
        check("R8 reset level on pin", pin_o, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule